// File: doc/BRIEF.md
# Key-Event Queue with Status-Coded Read Port

This block holds debounced key events from a key-matrix scanner until a host reads them. Each event is a 6-bit key number with a release flag, or a special repeat marker. The block stores up to 16 of them in arrival order. The host reads through one 8-bit port, and each read both presents and removes the oldest event. The byte it returns carries a more-data flag and a release flag beside the key number. It also uses reserved codes to report an empty queue, a lost event and a repeat marker.

An active-low interrupt tells the host that events are waiting. A configuration input selects how the interrupt goes away. In one setting it stays asserted until the queue has been drained. In the other, any host read releases it. The stored events are kept whatever else the device is doing, so they can be read at any time.

Top module: `keyfifo_status`

## Requirements
- R1: After reset the queue is empty, `rd_data` reads 0x3F and `irq_n` is 1.
- R2: For a stored key number from 0 to 61, `rd_data` is {more, release, key[5:0]}. Bit 7 is 1 when at least one further entry follows the one shown, bit 6 is 1 for a release and 0 for a press, and bits 5:0 are the key number.
- R3: While the queue is empty, `rd_data` is 0x3F. A read strobe in that state changes nothing, so a later push is still the first entry returned.
- R4: Keys 62 and 63 always read with bit 7 set, whether or not more entries follow: key 62 press is 0xBE, key 62 release is 0xFE, key 63 press is 0xBF and key 63 release is 0xFF.
- R5: A repeat-marker entry (`push_repeat`=1) reads as 0x3E when it is the only entry left and as 0x7E when more entries follow.
- R6: Entries leave in the order they arrived, and 16 entries fit with none lost.
- R7: A push into a full queue, with no pop in the same cycle, is dropped and the stored entries are kept. The next read returns 0x7F and removes nothing. Reads after that return the stored entries in order.
- R8: A push accepted into an empty queue drives `irq_n` to 0 on the following cycle.
- R9: With `clr_on_read`=0, `irq_n` returns to 1 in the cycle after the read that empties the queue, and it stays 0 while entries remain.
- R10: With `clr_on_read`=1, `irq_n` returns to 1 in the cycle after any read strobe, even if entries remain. A push accepted into an empty queue in that same cycle takes priority.
- R11: A push and a read in the same cycle on a non-empty queue both take effect. The read returns the old head, and the pushed entry is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store one event this cycle |
| push_key | input | 6 | Key number of the event |
| push_release | input | 1 | 1 for a release, 0 for a press |
| push_repeat | input | 1 | Event is a repeat marker (key and release ignored) |
| rd_strobe | input | 1 | Host read: consume the byte shown on rd_data |
| clr_on_read | input | 1 | Interrupt clear mode: 0 clears when the queue empties, 1 clears on any read |
| rd_data | output | 8 | Head event merged with status, or a reserved status code |
| irq_n | output | 1 | Active-low interrupt |

## Verification
`rd_data` is a combinational view of the current head and flags, so the bench samples it in the same cycle that the read strobe is driven, before the clock edge that consumes it. `irq_n` is a register, so its expected value after any push or read is sampled half a cycle after the next rising edge. Every stimulus is applied at a falling edge, and each check samples just before the next edge, so no check depends on the order of events at the active edge.

// File: rtl/keyfifo_status.sv
module keyfifo_status #(
  parameter int DEPTH = 16,
  parameter int KEYW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [KEYW-1:0] push_key,
  input  logic            push_release,
  input  logic            push_repeat,
  input  logic            rd_strobe,
  input  logic            clr_on_read,
  output logic [KEYW+1:0] rd_data,
  output logic            irq_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = KEYW + 2;
  localparam logic [KEYW-1:0] KEY_TOP  = {KEYW{1'b1}};
  localparam logic [KEYW-1:0] KEY_NEXT = {{(KEYW-1){1'b1}}, 1'b0};

  logic [EW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count, count_nx;
  logic            ovf_q, irq_q;

  wire empty   = (count == '0);
  wire full    = (count == CW'(DEPTH));
  wire pop     = rd_strobe && !ovf_q && !empty;
  wire push_ok = push_valid && (!full || pop);
  wire more    = (count > CW'(1));

  wire [EW-1:0]   head     = mem[rd_ptr];
  wire            head_rep = head[EW-1];
  wire            head_rel = head[KEYW];
  wire [KEYW-1:0] head_key = head[KEYW-1:0];
  wire            high_key = (head_key == KEY_TOP) || (head_key == KEY_NEXT);

  assign count_nx = count + CW'(push_ok) - CW'(pop);

  always_comb begin
    if (ovf_q)         rd_data = {1'b0, 1'b1, KEY_TOP};
    else if (empty)    rd_data = {1'b0, 1'b0, KEY_TOP};
    else if (head_rep) rd_data = {1'b0, more, KEY_NEXT};
    else if (high_key) rd_data = {1'b1, head_rel, head_key};
    else               rd_data = {more, head_rel, head_key};
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {push_repeat, push_release, push_key};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      count <= count_nx;
      if (push_valid && !push_ok)  ovf_q <= 1'b1;
      else if (rd_strobe && ovf_q) ovf_q <= 1'b0;
      if (push_ok && empty)                irq_q <= 1'b1;
      else if (clr_on_read && rd_strobe)   irq_q <= 1'b0;
      else if (!clr_on_read && count_nx == '0) irq_q <= 1'b0;
    end
  end

  assign irq_n = ~irq_q;
endmodule

module keyfifo_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          rd_strobe,
  input logic          clr_on_read,
  input logic          irq_n,
  input logic [CW-1:0] count,
  input logic          ovf
);
  // R8
  irq_on_first_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && count == '0) |=> !irq_n);
  // R3
  empty_read_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !push_valid && count == '0 && !ovf) |=> (count == '0));
  // R7
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !rd_strobe && count == CW'(DEPTH)) |=> (ovf && count == CW'(DEPTH)));
  // R9
  empty_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> irq_n);
  // R10
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on_read && rd_strobe && !(push_valid && count == '0)) |=> irq_n);
  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

bind keyfifo_status keyfifo_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .rd_strobe(rd_strobe),
  .clr_on_read(clr_on_read), .irq_n(irq_n), .count(count), .ovf(ovf_q)
);

// File: tb/keyfifo_status_tb.sv
module keyfifo_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0, push_release = 1'b0, push_repeat = 1'b0;
  logic rd_strobe = 1'b0, clr_on_read = 1'b0;
  logic [5:0] push_key = '0;
  logic [7:0] rd_data;
  logic irq_n;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  keyfifo_status u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_key(push_key),
    .push_release(push_release), .push_repeat(push_repeat), .rd_strobe(rd_strobe),
    .clr_on_read(clr_on_read), .rd_data(rd_data), .irq_n(irq_n)
  );

  // vector: {push, read, rep, rel, key[5:0], exp_rd[7:0], exp_irq_n_after}
  localparam int NV = 15;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,6'd5,  8'h00,1'b0},
    {1'b1,1'b0,1'b0,1'b1,6'd10, 8'h00,1'b0},
    {1'b1,1'b0,1'b0,1'b0,6'd62, 8'h00,1'b0},
    {1'b1,1'b0,1'b1,1'b0,6'd0,  8'h00,1'b0},
    {1'b1,1'b0,1'b0,1'b1,6'd63, 8'h00,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'h85,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'hCA,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'hBE,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'h7E,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'hFF,1'b1},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'h3F,1'b1},
    {1'b1,1'b0,1'b0,1'b1,6'd0,  8'h00,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'h40,1'b1},
    {1'b1,1'b0,1'b1,1'b0,6'd0,  8'h00,1'b0},
    {1'b0,1'b1,1'b0,1'b0,6'd0,  8'h3E,1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // drive at negedge; rd_data checked before the edge, irq_n after it
  task automatic step(input logic psh, input logic rd, input logic rep, input logic rel,
                      input logic [5:0] key, input bit chk_rd, input logic [7:0] exp_rd,
                      input bit chk_irq, input logic exp_irq, input string req);
    push_valid = psh; rd_strobe = rd; push_repeat = rep; push_release = rel; push_key = key;
    #1;
    if (chk_rd) check(req, rd_data, exp_rd);
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0; rd_strobe = 1'b0; push_repeat = 1'b0; push_release = 1'b0;
    if (chk_irq) check(req, {7'd0, irq_n}, {7'd0, exp_irq});
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check("R1 rd_data", rd_data, 8'h3F);
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    @(negedge clk);

    // R2 R4 R5 R8 R9 R3 mixed pattern, clear-when-empty mode
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      step(v[18], v[17], v[16], v[15], v[14:9], v[17], v[8:1], 1'b1, v[0],
           "R2 R4 R5 R8 R9 vector");
    end

    // R4 key 63 press and key 62 release with nothing behind them
    step(1, 0, 0, 0, 6'd63, 0, 8'h00, 1, 1'b0, "R8 push key63");
    step(0, 1, 0, 0, 6'd0, 1, 8'hBF, 1, 1'b1, "R4 key63 press");
    step(1, 0, 0, 1, 6'd62, 0, 8'h00, 0, 1'b0, "R4");
    step(0, 1, 0, 0, 6'd0, 1, 8'hFE, 1, 1'b1, "R4 key62 release");

    // R3 empty read leaves state alone
    step(0, 1, 0, 0, 6'd0, 1, 8'h3F, 1, 1'b1, "R3 empty read");
    step(1, 0, 0, 0, 6'd33, 0, 8'h00, 1, 1'b0, "R3 push after empty read");
    step(0, 1, 0, 0, 6'd0, 1, 8'h21, 1, 1'b1, "R3 first entry after empty read");

    // R6 R7 fill to 16, overflow, drain
    for (int k = 0; k < 16; k++)
      step(1, 0, 0, 0, 6'(k), 0, 8'h00, 0, 1'b0, "R6");
    step(1, 0, 0, 0, 6'd20, 0, 8'h00, 1, 1'b0, "R7 push into full");
    step(0, 1, 0, 0, 6'd0, 1, 8'h7F, 1, 1'b0, "R7 overflow code");
    for (int k = 0; k < 16; k++)
      step(0, 1, 0, 0, 6'd0, 1, (k < 15) ? (8'h80 | 8'(k)) : 8'h0F, 1, (k == 15),
           "R6 R7 R9 drain");
    step(0, 1, 0, 0, 6'd0, 1, 8'h3F, 0, 1'b1, "R7 dropped entry gone");

    // R11 push and pop together
    step(1, 0, 0, 0, 6'd1, 0, 8'h00, 0, 1'b0, "R11");
    step(1, 1, 0, 0, 6'd2, 1, 8'h01, 1, 1'b0, "R11 old head");
    step(0, 1, 0, 0, 6'd0, 1, 8'h02, 1, 1'b1, "R11 pushed entry kept");

    // R10 clear on any read
    clr_on_read = 1'b1;
    step(1, 0, 0, 0, 6'd7, 0, 8'h00, 1, 1'b0, "R10 assert");
    step(1, 0, 0, 1, 6'd8, 0, 8'h00, 1, 1'b0, "R10");
    step(0, 1, 0, 0, 6'd0, 1, 8'h87, 1, 1'b1, "R10 cleared with entry left");
    step(1, 0, 0, 0, 6'd9, 0, 8'h00, 1, 1'b1, "R10 no reassert on nonempty");
    step(0, 1, 0, 0, 6'd0, 1, 8'hC8, 0, 1'b1, "R10");
    step(0, 1, 0, 0, 6'd0, 1, 8'h09, 1, 1'b1, "R10 drained");
    step(1, 1, 0, 0, 6'd11, 1, 8'h3F, 1, 1'b0, "R10 push into empty wins");
    step(0, 1, 0, 0, 6'd0, 1, 8'h0B, 1, 1'b1, "R10");
    clr_on_read = 1'b0;

    // R1 reset with data queued
    step(1, 0, 0, 0, 6'd3, 0, 8'h00, 1, 1'b0, "R1");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset clears data", rd_data, 8'h3F);
    check("R1 reset clears irq", {7'd0, irq_n}, 8'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule